// File: doc/BRIEF.md
# Packed Byte Compare and Zap Unit

This unit is a single-cycle datapath slice for a processor execution stage. It takes two 64-bit operands, A and B, together with an operation code and a valid strobe. It produces a registered 64-bit result and a valid flag one clock later. It handles three kinds of operation. The first compares all eight byte lanes as unsigned values in parallel and packs the outcome into a lane mask. The second clears or keeps byte lanes of A under a mask held in the low byte of B. The third sign-extends a byte or a halfword taken from B.

The issue logic drives `in_vld` together with the operands and the code. The writeback side takes `res` in the cycle where `res_vld` is high. When `in_vld` is low the result register holds its last value.

Top module: `byte_lane_alu`

## Requirements
- R1: Code 0 (compare): for i = 0..7, result bit i is 1 exactly when A[8i+7:8i] >= B[8i+7:8i] as unsigned. Bit 0 comes from lane 0 (bits 7:0) and bit 7 from lane 7 (bits 63:56).
- R2: Code 0: result bits 63:8 are always zero.
- R3: Code 1 (zap): result lane i is zero when B[i] is 1. Otherwise it equals A lane i.
- R4: Code 2 (keep): result lane i equals A lane i when B[i] is 1. Otherwise it is zero.
- R5: For codes 1 and 2, B[63:8] has no effect on the result.
- R6: Code 3: the result is B[7:0] with bit 7 copied into bits 63:8. A has no effect.
- R7: Code 4: the result is B[15:0] with bit 15 copied into bits 63:16. A has no effect.
- R8: Codes 5, 6 and 7 produce a zero result.
- R9: `res_vld` is high in the cycle after a cycle with `in_vld` high, and low otherwise. `res` is updated only on accepted inputs and otherwise holds its value.
- R10: A synchronous active-high reset clears `res` and `res_vld` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operands and code are valid |
| op | input | 3 | Operation code (0 compare, 1 zap, 2 keep, 3 sext byte, 4 sext half) |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B / lane mask |
| res | output | 64 | Registered result |
| res_vld | output | 1 | Result valid |

## Verification
The bench builds the unit with its fixed 64-bit width and 3-bit code, because the lane count is inherent to the operations. With eight lanes, the masks 0x00 and 0xFF and every single-lane difference in a compare are within reach of directed stimulus. The directed cases cover equal bytes in every lane, A of zero against B of all ones, and nonzero upper B bits under both mask operations. Random operands and codes are then compared every clock against a lane-by-lane loop model that includes the held value when `in_vld` is low.

// File: rtl/byte_lane_alu.sv
module byte_lane_alu (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_vld,
  input  logic [2:0]  op,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  output logic [63:0] res,
  output logic        res_vld
);

  logic [7:0]  ge_mask;
  logic [63:0] lane_keep;
  logic [63:0] nxt;

  genvar g;
  generate
    for (g = 0; g < 8; g++) begin : g_lane
      assign ge_mask[g] = opa[8*g +: 8] >= opb[8*g +: 8];
      assign lane_keep[8*g +: 8] = {8{opb[g]}};
    end
  endgenerate

  always_comb begin
    case (op)
      3'd0:    nxt = {56'd0, ge_mask};
      3'd1:    nxt = opa & ~lane_keep;
      3'd2:    nxt = opa & lane_keep;
      3'd3:    nxt = {{56{opb[7]}}, opb[7:0]};
      3'd4:    nxt = {{48{opb[15]}}, opb[15:0]};
      default: nxt = 64'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= 64'd0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) res <= nxt;
    end
  end

  // R9
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld);
  // R9
  vld_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !res_vld);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(res));
  // R2
  cmp_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op == 3'd0) |=> res[63:8] == 56'd0);
  // R8
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op > 3'd4) |=> res == 64'd0);
  // R6
  sextb_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op == 3'd3) |=> (res[7:0] == $past(opb[7:0])) && (res[63:8] == {56{res[7]}}));

endmodule

// File: tb/byte_lane_alu_tb.sv
module byte_lane_alu_tb;
  logic clk = 0, rst = 1, in_vld = 0;
  logic [2:0] op = 0;
  logic [63:0] opa = 0, opb = 0;
  logic [63:0] res;
  logic res_vld;
  int checks = 0, errors = 0;
  logic [63:0] exp_res = 0;
  logic exp_vld = 0;

  always #4 clk = ~clk;

  byte_lane_alu u_dut (.clk, .rst, .in_vld, .op, .opa, .opb, .res, .res_vld);

  function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = 0;
    case (o)
      0: for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
      1: for (int i = 0; i < 8; i++) r[8*i +: 8] = b[i] ? 8'h00 : a[8*i +: 8];
      2: for (int i = 0; i < 8; i++) r[8*i +: 8] = b[i] ? a[8*i +: 8] : 8'h00;
      3: begin r = {56'd0, b[7:0]}; if (b[7]) r[63:8] = '1; end
      4: begin r = {48'd0, b[15:0]}; if (b[15]) r[63:16] = '1; end
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      0: return "R1/R2"; 1: return "R3/R5"; 2: return "R4/R5";
      3: return "R6"; 4: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic cmp(input string rq);
    checks++;
    if (res !== exp_res || res_vld !== exp_vld) begin
      errors++;
      $display("FAIL %s: res=%h vld=%b expected res=%h vld=%b", rq, res, res_vld, exp_res, exp_vld);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
    in_vld = v; op = o; opa = a; opb = b;
    @(posedge clk);
    exp_vld = v;
    if (v) exp_res = model(o, a, b);
    #2;
    cmp(v ? tag(o) : "R9");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    cmp("R10");
    rst = 0;
    step(1, 0, 64'h1122334455667788, 64'h1122334455667788); // R1 all equal
    step(1, 0, 64'h0, 64'hFFFFFFFFFFFFFFFF);                 // R1 zero vs ones
    step(1, 0, 64'h0180_7F00_FF01_0080, 64'h0081_7E01_FE00_0180); // R1 lane order
    step(0, 0, 64'h0, 64'h0);                                // R9 hold
    step(1, 1, 64'hA5A5_5A5A_1234_5678, 64'hFFFF_FFFF_FFFF_FF00); // R5 mask 00
    step(1, 1, 64'hA5A5_5A5A_1234_5678, 64'h0000_0000_0000_00FF); // R3 mask FF
    step(1, 2, 64'hA5A5_5A5A_1234_5678, 64'hFFFF_0000_0000_0000); // R5 mask 00
    step(1, 2, 64'hA5A5_5A5A_1234_5678, 64'h0000_0000_0000_00FF); // R4 mask FF
    step(1, 2, 64'hA5A5_5A5A_1234_5678, 64'h1234_5678_9ABC_DE5A); // R4
    step(1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0080); // R6
    step(1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FF7F); // R6
    step(1, 4, 64'h0, 64'h0000_0000_0000_8001);              // R7
    step(1, 4, 64'hFFFF, 64'hFFFF_FFFF_FFFF_7FFF);           // R7
    step(1, 5, 64'h1, 64'h1);                                // R8
    step(1, 7, 64'hFFFF, 64'hFFFF);                          // R8
    for (int n = 0; n < 2000; n++)
      step(($urandom % 4) != 0, 3'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    rst = 1;
    @(posedge clk);
    exp_res = 0; exp_vld = 0;
    #2;
    cmp("R10");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule